// File: doc/BRIEF.md
# Byte-Command I2C Master

This block is an I2C bus master that carries out exactly one byte per command. A host writes an 11-bit command word. The word asks for a START (or repeated START) ahead of the byte, or for a lone STOP. It also sets the level the master puts on the acknowledge slot and carries the eight bits to shift. The block then drives the open-drain clock and data lines through pull-down enables and samples the data line. At the end it publishes a reception word holding the byte seen on the bus, the acknowledge bit from the target, a lost-arbitration flag and a bus-ownership flag. A single-cycle completion pulse is the only sign that the byte is done, because no busy flag exists.

A divider word sets the bus timing. Its upper half is the number of clock cycles SCL stays high in each bit slot, and its lower half is the length of the whole slot. A two-bit control word holds the bus logic in reset with both lines released until both of its bits are set. The first byte after a START is treated as an address. If its bit 0 is 1, the bytes that follow without a START are received rather than sent.

Top module: `i2cb_master`

## Requirements
- R1: Command word layout: bit 10 is START, bit 9 is STOP, bit 8 is the acknowledge-slot level (1 = release/NACK, 0 = drive low/ACK), and bits 7:0 are the byte. A command is taken only while no byte or STOP is in progress. A write that arrives during one has no effect on the bus, the completion pulse or the reception word.
- R2: A START slot lasts one full period. SCL is released throughout, and SDA is released for the first high-count cycles and pulled low for the rest. Each data or acknowledge slot pulls SCL low for (period − high) cycles and releases it for the high count. Data bits go out most significant bit first, and a 0 pulls SDA low for the whole slot.
- R3: Divider word: bits 31:16 are the SCL high count and bits 15:0 are the slot period, both in clock cycles. The reset values come from parameters. The word is written while idle, with 3 ≤ high < period.
- R4: In the ninth (acknowledge) slot the master pulls SDA low when bit 8 is 0 and releases it when bit 8 is 1. The sampled SDA level goes to reception bit 11, where 1 means NACK.
- R5: A START command whose bit 0 is 1 switches to receive mode. Later commands without START then release SDA for all eight data slots and store the sampled bits in reception bits 7:0, MSB first. A START command whose bit 0 is 0 switches back to transmit.
- R6: A command with bit 9 set produces a single STOP slot and shifts no byte. SCL is low for (period − high) cycles. SDA is held low until the sample point and released after it, so it rises while SCL is high. The STOP clears reception bit 12 and leaves bits 11, 9 and 7:0 unchanged.
- R7: SDA is sampled at cycle (period − high) + high/2 of each data and acknowledge slot, counting the slot's first cycle as 0.
- R8: If SDA reads low at a sample point of a transmitted 1 bit, arbitration is lost. From the next cycle both lines are released and no STOP is made. The reception word then shows bit 9 = 1, bit 11 = 1, bit 12 = 0 and bits 7:0 as the bits sampled so far, and the completion pulse fires.
- R9: The completion pulse is high for exactly one cycle: the cycle after the last cycle of the acknowledge slot, of the STOP slot, or of the losing sample. Reception bits 11, 9 and 7:0 change only in that cycle.
- R10: After a byte that leaves the bus owned, the master keeps SCL pulled low and SDA released until the next command. Reception bit 12 is 1 from the START command on.
- R11: Control word: bit 0 = 1 releases the bus-logic reset and bit 1 = 1 enables the outputs. Only the value 3 runs the block. Any other value releases both lines at once, clears the reception word and ownership, and makes commands have no effect.
- R12: After reset both lines are released, the completion pulse is low, the reception word is 0, and the control word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_word | input | 11 | Command: start, stop, ack level, byte |
| div_we | input | 1 | Divider word write strobe |
| div_word | input | 32 | SCL high count (31:16), slot period (15:0) |
| ctl_we | input | 1 | Control word write strobe |
| ctl_word | input | 2 | Output enable (1), reset release (0) |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| rx_word | output | 13 | Ownership (12), NACK seen (11), arbitration lost (9), byte (7:0) |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with a reset period of 10 and a high count of 5, so a whole byte takes about a hundred cycles and the sample point lands at an odd slot cycle. It then writes a period of 12 with a high count of 4. The low phase becomes twice the high phase, and the sample point moves to cycle 10. This shows that both halves of the divider word are used independently. With these short slots, the bench can cover a write, a NACKed write, a repeated-START read with ACK and NACK, a STOP, a mid-byte command, an arbitration loss and a bus reset while the bus is owned, all against a per-cycle model.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned CMD_W  = BYTE_W + 3;
    localparam int unsigned RX_W   = BYTE_W + 5;
    localparam int unsigned BIT_IW = $clog2(BYTE_W + 1);

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_START,
        PH_BIT,
        PH_STOP
    } phase_e;

    typedef struct packed {
        logic              start;
        logic              stop;
        logic              nack;
        logic [BYTE_W-1:0] dat;
    } cmd_t;

    typedef struct packed {
        logic              own;
        logic              nack_seen;
        logic              rsv1;
        logic              arb_lost;
        logic              rsv0;
        logic [BYTE_W-1:0] dat;
    } rx_t;

    function automatic cmd_t unpack_cmd(input logic [CMD_W-1:0] w);
        return cmd_t'(w);
    endfunction

    function automatic logic ctl_runs(input logic [1:0] c);
        return c == 2'b11;
    endfunction
endpackage

// File: rtl/i2cb_cfg.sv
module i2cb_cfg
    import i2cb_pkg::*;
#(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned DEF_HI  = 125,
    parameter int unsigned DEF_PER = 250
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               div_we,
    input  logic [2*CNT_W-1:0] div_word,
    input  logic               ctl_we,
    input  logic [1:0]         ctl_word,
    output logic [CNT_W-1:0]   hi_cnt,
    output logic [CNT_W-1:0]   per_cnt,
    output logic               run
);
    logic [1:0] ctl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt  <= CNT_W'(DEF_HI);
            per_cnt <= CNT_W'(DEF_PER);
            ctl_q   <= 2'b00;
        end else begin
            if (div_we) begin
                hi_cnt  <= div_word[2*CNT_W-1:CNT_W];
                per_cnt <= div_word[CNT_W-1:0];
            end
            if (ctl_we) ctl_q <= ctl_word;
        end
    end

    assign run = ctl_runs(ctl_q);
endmodule

// File: rtl/i2cb_slot_timer.sv
module i2cb_slot_timer #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic [CNT_W-1:0] hi_cnt,
    input  logic [CNT_W-1:0] per_cnt,
    output logic             slot_end,
    output logic             smp,
    output logic             scl_high,
    output logic             start_low,
    output logic             stop_rel
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] low_cnt;
    logic [CNT_W-1:0] smp_pt;

    assign low_cnt = per_cnt - hi_cnt;
    assign smp_pt  = low_cnt + (hi_cnt >> 1);

    always_ff @(posedge clk) begin
        if (rst || !active)                   cnt <= '0;
        else if (cnt == per_cnt - CNT_W'(1))  cnt <= '0;
        else                                  cnt <= cnt + CNT_W'(1);
    end

    assign slot_end  = active && (cnt == per_cnt - CNT_W'(1));
    assign smp       = active && (cnt == smp_pt);
    assign scl_high  = cnt >= low_cnt;
    assign start_low = cnt >= hi_cnt;
    assign stop_rel  = cnt >= smp_pt;

    // R2
    cnt_in_slot_chk: assert property (@(posedge clk) disable iff (rst)
        active |-> (cnt < per_cnt));
endmodule

// File: rtl/i2cb_engine.sv
module i2cb_engine
    import i2cb_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_we,
    input  logic [CMD_W-1:0] cmd_word,
    input  logic            sda_in,
    input  logic            slot_end,
    input  logic            smp,
    input  logic            scl_high,
    input  logic            start_low,
    input  logic            stop_rel,
    output logic            active,
    output logic            scl_drv,
    output logic            sda_drv,
    output logic [RX_W-1:0] rx_word,
    output logic            done
);
    phase_e            phase;
    cmd_t              cmd;
    logic [BIT_IW-1:0] bitn;
    logic [BYTE_W-1:0] txd, rxd, data_q;
    logic              nack_q, rx_mode, rd_mode, own, ack_q, lrb_q, lab_q, done_q;
    logic              ack_slot, lost;
    rx_t               rx_s;

    assign cmd      = unpack_cmd(cmd_word);
    assign ack_slot = bitn == BIT_IW'(BYTE_W);
    assign lost     = (phase == PH_BIT) && !ack_slot && !rx_mode && txd[BYTE_W-1]
                      && smp && !sda_in;
    assign active   = phase != PH_IDLE;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            bitn    <= '0;
            txd     <= '0;
            rxd     <= '0;
            data_q  <= '0;
            nack_q  <= 1'b0;
            rx_mode <= 1'b0;
            rd_mode <= 1'b0;
            own     <= 1'b0;
            ack_q   <= 1'b0;
            lrb_q   <= 1'b0;
            lab_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (phase)
                PH_IDLE: if (cmd_we) begin
                    txd    <= cmd.dat;
                    nack_q <= cmd.nack;
                    bitn   <= '0;
                    rxd    <= '0;
                    if (cmd.stop) begin
                        phase <= PH_STOP;
                    end else begin
                        rx_mode <= rd_mode && !cmd.start;
                        if (cmd.start) begin
                            rd_mode <= cmd.dat[0];
                            own     <= 1'b1;
                            phase   <= PH_START;
                        end else begin
                            phase <= PH_BIT;
                        end
                    end
                end
                PH_START: if (slot_end) phase <= PH_BIT;
                PH_BIT: begin
                    if (lost) begin
                        phase   <= PH_IDLE;
                        own     <= 1'b0;
                        rd_mode <= 1'b0;
                        done_q  <= 1'b1;
                        lab_q   <= 1'b1;
                        lrb_q   <= 1'b1;
                        data_q  <= {rxd[BYTE_W-2:0], sda_in};
                    end else begin
                        if (smp && !ack_slot) rxd   <= {rxd[BYTE_W-2:0], sda_in};
                        if (smp && ack_slot)  ack_q <= sda_in;
                        if (slot_end) begin
                            if (ack_slot) begin
                                phase  <= PH_IDLE;
                                done_q <= 1'b1;
                                data_q <= rxd;
                                lrb_q  <= ack_q;
                                lab_q  <= 1'b0;
                            end else begin
                                bitn <= bitn + BIT_IW'(1);
                                txd  <= {txd[BYTE_W-2:0], 1'b0};
                            end
                        end
                    end
                end
                PH_STOP: if (slot_end) begin
                    phase   <= PH_IDLE;
                    own     <= 1'b0;
                    rd_mode <= 1'b0;
                    done_q  <= 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        scl_drv = 1'b0;
        sda_drv = 1'b0;
        unique case (phase)
            PH_IDLE:  scl_drv = own;
            PH_START: sda_drv = start_low;
            PH_BIT: begin
                scl_drv = !scl_high;
                sda_drv = ack_slot ? !nack_q : (!rx_mode && !txd[BYTE_W-1]);
            end
            PH_STOP: begin
                scl_drv = !scl_high;
                sda_drv = !stop_rel;
            end
            default: ;
        endcase
    end

    assign rx_s    = '{own: own, nack_seen: lrb_q, rsv1: 1'b0, arb_lost: lab_q,
                       rsv0: 1'b0, dat: data_q};
    assign rx_word = rx_s;
    assign done    = done_q;

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);
    // R9
    rx_data_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(data_q) || !$stable(lab_q) || !$stable(lrb_q)) |-> done_q);
    // R8
    arb_release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lab_q) |-> (!scl_drv && !sda_drv));
    // R10
    own_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done_q && own) |-> (scl_drv && !sda_drv));
    // R1
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE && cmd_we) |=> ($stable(nack_q) && $stable(rx_mode)));
endmodule

// File: rtl/i2cb_master.sv
module i2cb_master
    import i2cb_pkg::*;
#(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned DEF_HI  = 125,
    parameter int unsigned DEF_PER = 250
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_we,
    input  logic [CMD_W-1:0]   cmd_word,
    input  logic               div_we,
    input  logic [2*CNT_W-1:0] div_word,
    input  logic               ctl_we,
    input  logic [1:0]         ctl_word,
    input  logic               sda_in,
    output logic               scl_oe,
    output logic               sda_oe,
    output logic [RX_W-1:0]    rx_word,
    output logic               done
);
    logic [CNT_W-1:0] hi_cnt, per_cnt;
    logic run, eng_rst, active;
    logic slot_end, smp, scl_high, start_low, stop_rel;
    logic scl_drv, sda_drv;

    assign eng_rst = rst || !run;

    i2cb_cfg #(.CNT_W(CNT_W), .DEF_HI(DEF_HI), .DEF_PER(DEF_PER)) u_cfg (
        .clk(clk), .rst(rst), .div_we(div_we), .div_word(div_word),
        .ctl_we(ctl_we), .ctl_word(ctl_word),
        .hi_cnt(hi_cnt), .per_cnt(per_cnt), .run(run)
    );

    i2cb_slot_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(eng_rst), .active(active),
        .hi_cnt(hi_cnt), .per_cnt(per_cnt),
        .slot_end(slot_end), .smp(smp), .scl_high(scl_high),
        .start_low(start_low), .stop_rel(stop_rel)
    );

    i2cb_engine u_eng (
        .clk(clk), .rst(eng_rst), .cmd_we(cmd_we), .cmd_word(cmd_word),
        .sda_in(sda_in), .slot_end(slot_end), .smp(smp), .scl_high(scl_high),
        .start_low(start_low), .stop_rel(stop_rel), .active(active),
        .scl_drv(scl_drv), .sda_drv(sda_drv), .rx_word(rx_word), .done(done)
    );

    assign scl_oe = scl_drv && run;
    assign sda_oe = sda_drv && run;

    // R11
    halted_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> (!done && !active));
endmodule

// File: tb/i2cb_master_tb.sv
module i2cb_master_tb;
    localparam int PER0 = 10;
    localparam int HI0  = 5;

    logic        clk = 1'b0, rst = 1'b1;
    logic        cmd_we = 1'b0, div_we = 1'b0, ctl_we = 1'b0;
    logic [10:0] cmd_word = '0;
    logic [31:0] div_word = '0;
    logic [1:0]  ctl_word = '0;
    logic        sda_in, scl_oe, sda_oe, done;
    logic [12:0] rx_word;
    logic        slv = 1'b0;

    assign sda_in = !(sda_oe || slv);
    always #2 clk = ~clk;

    i2cb_master #(.CNT_W(16), .DEF_HI(HI0), .DEF_PER(PER0)) u_dut (
        .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_word(cmd_word),
        .div_we(div_we), .div_word(div_word), .ctl_we(ctl_we), .ctl_word(ctl_word),
        .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe), .rx_word(rx_word), .done(done)
    );

    typedef struct {
        bit scl; bit sda; bit slv; bit dn; bit own; bit upd;
        bit [7:0] d; bit lrb; bit lab;
    } ent_t;

    ent_t  q[$];
    int    checks = 0, fails = 0;
    string cur = "R12";
    bit    m_own = 0, m_rd = 0, m_run = 0, m_lrb = 0, m_lab = 0, active_cmp = 0;
    bit [7:0] m_d = 0;
    int    per = PER0, hi = HI0, settle = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic void push(bit scl, bit sda, bit s, bit dn, bit own, bit upd,
                                 bit [7:0] d, bit lrb, bit lab);
        ent_t e;
        e.scl = scl; e.sda = sda; e.slv = s; e.dn = dn; e.own = own; e.upd = upd;
        e.d = d; e.lrb = lrb; e.lab = lab;
        q.push_back(e);
    endfunction

    // expected bus behaviour of one command, one entry per clock cycle
    function automatic void build(bit [10:0] w, bit [7:0] sb, bit sack, int contend);
        int low = per - hi;
        int sp  = low + hi / 2;
        bit own = m_own;
        bit rx;
        bit [7:0] acc = 0;
        bit mb, s, bus, ackbus;
        if (w[9]) begin
            for (int c = 0; c < per; c++) push(c < low, c < sp, 0, 0, own, 0, 0, 0, 0);
            push(0, 0, 0, 1, 0, 0, 0, 0, 0);
            m_rd = 0;
            return;
        end
        rx = m_rd && !w[10];
        if (w[10]) begin
            m_rd = w[0];
            own  = 1;
            for (int c = 0; c < per; c++) push(0, c >= hi, 0, 0, own, 0, 0, 0, 0);
        end
        for (int b = 0; b < 8; b++) begin
            mb  = rx ? 1'b1 : w[7-b];
            s   = rx ? !sb[7-b] : (contend == b);
            bus = mb && !s;
            for (int c = 0; c < per; c++) begin
                push(c < low, !mb, s, 0, own, 0, 0, 0, 0);
                if (c == sp) begin
                    acc = {acc[6:0], bus};
                    if (!rx && mb && !bus) begin
                        push(0, 0, 0, 1, 0, 1, acc, 1, 1);
                        m_rd = 0;
                        return;
                    end
                end
            end
        end
        ackbus = !(!w[8] || sack);
        for (int c = 0; c < per; c++) push(c < low, !w[8], sack, 0, own, 0, 0, 0, 0);
        push(own, 0, 0, 1, own, 1, acc, ackbus, 0);
    endfunction

    always @(posedge clk) begin : cmp
        ent_t e;
        bit es, ed, edn;
        #1;
        if (active_cmp) begin
            if (q.size() > 0) begin
                e = q.pop_front();
                slv = e.slv; m_own = e.own;
                es = e.scl; ed = e.sda; edn = e.dn;
                if (e.upd) begin m_d = e.d; m_lrb = e.lrb; m_lab = e.lab; end
            end else begin
                slv = 0; es = m_own && m_run; ed = 0; edn = 0;
            end
            chk(cur, "scl_oe", int'(scl_oe), int'(es));
            chk(cur, "sda_oe", int'(sda_oe), int'(ed));
            chk(cur, "done", int'(done), int'(edn));
            if (settle > 0) settle--;
            else chk(cur, "rx_word", int'(rx_word),
                     int'({m_own, m_lrb, 1'b0, m_lab, 1'b0, m_d}));
        end
    end

    task automatic cmd(input bit [10:0] w, input bit [7:0] sb, input bit sack,
                       input int contend, input bit wait_done);
        @(negedge clk); cmd_we = 1; cmd_word = w;
        @(posedge clk);
        if (q.size() == 0 && m_run) build(w, sb, sack, contend);
        @(negedge clk); cmd_we = 0;
        if (wait_done) begin
            while (q.size() > 0) @(negedge clk);
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic ctl(input bit [1:0] v);
        @(negedge clk); ctl_we = 1; ctl_word = v;
        @(posedge clk);
        m_run = (v == 2'b11);
        if (!m_run) begin m_own = 0; m_rd = 0; m_d = 0; m_lrb = 0; m_lab = 0; end
        settle = 3;
        @(negedge clk); ctl_we = 0;
        repeat (4) @(negedge clk);
    endtask

    task automatic divider(input int h, input int p);
        @(negedge clk); div_we = 1; div_word = {16'(h), 16'(p)};
        @(posedge clk); per = p; hi = h;
        @(negedge clk); div_we = 0;
    endtask

    initial begin : wdog
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL R12 watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R12: reset state
        chk("R12", "scl_oe", int'(scl_oe), 0);
        chk("R12", "sda_oe", int'(sda_oe), 0);
        chk("R12", "done", int'(done), 0);
        chk("R12", "rx_word", int'(rx_word), 0);
        active_cmp = 1;

        // R11: control word 0 and 1 keep commands from acting
        cur = "R11";
        cmd({3'b101, 8'hB4}, 8'hFF, 1, -1, 1);
        ctl(2'b01);
        cmd({3'b101, 8'hB4}, 8'hFF, 1, -1, 1);
        ctl(2'b11);

        // R2 / R4: address write, target acknowledges
        cur = "R2";
        cmd({3'b101, 8'hB4}, 8'hFF, 1, -1, 1);
        chk("R4", "rx nack bit", int'(rx_word[11]), 0);
        // R10: owned idle keeps SCL low
        cur = "R10";
        repeat (20) @(negedge clk);
        chk("R10", "scl held", int'(scl_oe), 1);
        // R4: data byte NACKed by target
        cur = "R4";
        cmd({3'b001, 8'h3C}, 8'hFF, 0, -1, 1);
        chk("R4", "rx nack bit", int'(rx_word[11]), 1);
        // R1: second command during a byte is ignored
        cur = "R1";
        cmd({3'b001, 8'hA5}, 8'hFF, 1, -1, 0);
        repeat (15) @(negedge clk);
        cmd({3'b101, 8'h00}, 8'hFF, 1, -1, 1);
        chk("R1", "rx byte", int'(rx_word[7:0]), 8'hA5);
        // R6: stop
        cur = "R6";
        cmd({3'b011, 8'h00}, 8'hFF, 0, -1, 1);
        chk("R6", "own cleared", int'(rx_word[12]), 0);

        // R3: asymmetric divider, R5/R7 read with repeated start
        divider(4, 12);
        cur = "R3";
        cmd({3'b101, 8'h40}, 8'hFF, 1, -1, 1);
        cur = "R5/R7";
        cmd({3'b101, 8'hB5}, 8'hFF, 1, -1, 1);
        cmd({3'b000, 8'h00}, 8'h96, 0, -1, 1);
        chk("R5", "rx byte", int'(rx_word[7:0]), 8'h96);
        cmd({3'b001, 8'h00}, 8'h2D, 0, -1, 1);
        chk("R5", "rx byte final", int'(rx_word[7:0]), 8'h2D);
        chk("R4", "final nack", int'(rx_word[11]), 1);
        cur = "R6";
        cmd({3'b011, 8'h00}, 8'hFF, 0, -1, 1);

        // R8: arbitration lost on third bit of 0xF0
        cur = "R8";
        cmd({3'b101, 8'hF0}, 8'hFF, 1, 2, 1);
        chk("R8", "arb flag", int'(rx_word[9]), 1);
        chk("R8", "own", int'(rx_word[12]), 0);

        // R11: bus reset while owned
        cur = "R11";
        cmd({3'b101, 8'h22}, 8'hFF, 1, -1, 1);
        ctl(2'b01);
        chk("R11", "scl released", int'(scl_oe), 0);
        chk("R11", "rx cleared", int'(rx_word), 0);
        ctl(2'b11);
        cur = "R9";
        cmd({3'b101, 8'h5A}, 8'hFF, 1, -1, 1);
        cmd({3'b011, 8'h00}, 8'hFF, 0, -1, 1);

        repeat (5) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule